// File: doc/BRIEF.md
# Store-Conditional Reservation Unit

This block keeps the single reservation flag that ties a load-and-reserve to a later conditional word store. A load-and-reserve pulse arms the flag and records the reserved address. An explicit clear pulse drops the flag. A store-conditional request supplies a base register value, a flag that says the base register field names register zero, an index register value, the store data and the current summary-overflow bit.

For each request the unit forms the effective address. It decides whether the word store may go to memory, which happens only while the flag is armed. It then returns a 4-bit condition field. Every store-conditional disarms the flag, whether or not the store went through.

All results are registered. The memory write strobe, address, data and the condition field appear together for exactly one cycle after the request. The flag and recorded address are visible at all times so that the surrounding pipeline can inspect them.

Top module: `rsv_unit`

## Requirements
- R1: A store-conditional request accepted while the flag is set raises `mem_we` for one cycle, starting on the clock edge after the request, with `mem_wdata` equal to the request's `st_data`.
- R2: A store-conditional request accepted while the flag is clear leaves `mem_we` low.
- R3: On success, `cond_out` is {lt=0, gt=0, eq=1, so}, i.e. 4'b0010 | so_in, with bit 0 the copied summary-overflow bit and bit 1 the equal bit.
- R4: On failure, `cond_out` is {0,0,0,so}, i.e. 4'b0000 | so_in.
- R5: After any store-conditional request without a same-cycle set pulse, `rsv_valid` is 0.
- R6: `mem_addr` equals (`ra_zero` ? 0 : `ra_val`) + `rb_val`, modulo 2^ADDR_W.
- R7: A set pulse makes `rsv_valid` 1 and `rsv_addr` equal to `rsv_addr_in` on the next cycle.
- R8: A clear pulse without a same-cycle set pulse makes `rsv_valid` 0 on the next cycle.
- R9: When a set pulse meets a store-conditional or a clear pulse in the same cycle, the store-conditional is judged on the flag held before that cycle, and the flag is 1 afterwards.
- R10: `cond_vld` is high for exactly the one cycle after each request. `mem_we`, `mem_addr`, `mem_wdata` and `cond_out` are all zero whenever `cond_vld` is low.
- R11: Synchronous active-high reset clears the flag, the recorded address and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_set | input | 1 | Load-and-reserve pulse: arm flag |
| rsv_addr_in | input | ADDR_W | Address to record with the reservation |
| rsv_clr | input | 1 | Pulse that drops the reservation |
| sc_req | input | 1 | Store-conditional request |
| ra_zero | input | 1 | Base register field is zero: use 0 as base |
| ra_val | input | ADDR_W | Base register value |
| rb_val | input | ADDR_W | Index register value |
| st_data | input | DATA_W | Word to store |
| so_in | input | 1 | Summary-overflow bit to copy |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Effective address of the store |
| mem_wdata | output | DATA_W | Data of the store |
| cond_vld | output | 1 | Condition field valid |
| cond_out | output | 4 | Condition field {lt, gt, eq, so} |
| rsv_valid | output | 1 | Current reservation flag |
| rsv_addr | output | ADDR_W | Recorded reservation address |

## Verification
The assertions watch every cycle for a write strobe without a prior armed flag and request. They also check the shape of the condition field against the strobe, the copied overflow bit, the one-cycle validity, the effective-address sum, and the next-state rules for set, clear and store-conditional. Only the bench's scenarios show the ordered histories: a failure after a success, a clear between set and store, the same-cycle set-with-request cases judged on both prior flag values, address wrap-around, and reset in the middle of a reservation.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // condition field bit positions {lt, gt, eq, so}
  localparam int unsigned CR_W   = 4;
  localparam int unsigned CR_SO  = 0;
  localparam int unsigned CR_EQ  = 1;

  typedef logic [CR_W-1:0] cr_field_t;

  function automatic cr_field_t make_cr(input logic ok, input logic so);
    cr_field_t f;
    f        = '0;
    f[CR_EQ] = ok;
    f[CR_SO] = so;
    return f;
  endfunction
endpackage

// File: rtl/rsv_ea_gen.sv
module rsv_ea_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              base_is_zero,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] base_eff;

  always_comb begin
    base_eff = base_is_zero ? '0 : base_val;
    ea       = base_eff + index_val;
  end
endmodule

// File: rtl/rsv_flag_reg.sv
module rsv_flag_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              drop,
  input  logic              consume,
  output logic              flag,
  output logic [ADDR_W-1:0] flag_addr
);
  logic flag_nxt;

  // arming dominates; either a clear or a consuming store disarms
  always_comb begin
    flag_nxt = flag;
    if (arm)                flag_nxt = 1'b1;
    else if (drop || consume) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      flag_addr <= '0;
    end else begin
      flag <= flag_nxt;
      if (arm) flag_addr <= arm_addr;
    end
  end
endmodule

// File: rtl/rsv_sc_resolve.sv
module rsv_sc_resolve
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              held_flag,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] wdata,
  input  logic              so,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              vld_q,
  output cr_field_t         cr_q
);
  logic ok;

  assign ok = req && held_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      cr_q   <= '0;
    end else begin
      we_q   <= ok;
      vld_q  <= req;
      addr_q <= ok ? ea : '0;
      data_q <= ok ? wdata : '0;
      cr_q   <= req ? make_cr(ok, so) : '0;
    end
  end
endmodule

// File: rtl/rsv_unit.sv
module rsv_unit
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsv_set,
  input  logic [ADDR_W-1:0] rsv_addr_in,
  input  logic              rsv_clr,
  input  logic              sc_req,
  input  logic              ra_zero,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] rb_val,
  input  logic [DATA_W-1:0] st_data,
  input  logic              so_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cond_vld,
  output logic [3:0]        cond_out,
  output logic              rsv_valid,
  output logic [ADDR_W-1:0] rsv_addr
);
  logic [ADDR_W-1:0] ea;
  cr_field_t         cr;

  rsv_ea_gen #(.ADDR_W(ADDR_W)) u_ea (
    .base_is_zero (ra_zero),
    .base_val     (ra_val),
    .index_val    (rb_val),
    .ea           (ea)
  );

  rsv_flag_reg #(.ADDR_W(ADDR_W)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .arm       (rsv_set),
    .arm_addr  (rsv_addr_in),
    .drop      (rsv_clr),
    .consume   (sc_req),
    .flag      (rsv_valid),
    .flag_addr (rsv_addr)
  );

  rsv_sc_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .req       (sc_req),
    .held_flag (rsv_valid),
    .ea        (ea),
    .wdata     (st_data),
    .so        (so_in),
    .we_q      (mem_we),
    .addr_q    (mem_addr),
    .data_q    (mem_wdata),
    .vld_q     (cond_vld),
    .cr_q      (cr)
  );

  assign cond_out = cr;
endmodule

// File: rtl/rsv_unit_chk.sv
module rsv_unit_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rsv_set,
  input logic              rsv_clr,
  input logic              sc_req,
  input logic              ra_zero,
  input logic [ADDR_W-1:0] ra_val,
  input logic [ADDR_W-1:0] rb_val,
  input logic [DATA_W-1:0] st_data,
  input logic              so_in,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              cond_vld,
  input logic [3:0]        cond_out,
  input logic              rsv_valid
);
  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_WE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    mem_we |-> ($past(rsv_valid) && $past(sc_req))); // R2
  AST_WE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (sc_req && rsv_valid) |=> (mem_we && mem_wdata == $past(st_data))); // R1
  AST_CR_SHAPE: assert property (@(posedge clk) disable iff (rst)
    cond_vld |-> (cond_out[3:2] == 2'b00 && cond_out[1] == mem_we)); // R3
  AST_SO_COPY: assert property (@(posedge clk) disable iff (rst)
    sc_req |=> (cond_out[0] == $past(so_in))); // R4
  AST_SC_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !rsv_set) |=> !rsv_valid); // R5
  AST_EA_SUM: assert property (@(posedge clk) disable iff (rst)
    (sc_req && rsv_valid) |=> mem_addr == (($past(ra_zero) ? '0 : $past(ra_val)) + $past(rb_val))); // R6
  AST_SET_ARMS: assert property (@(posedge clk) disable iff (rst)
    rsv_set |=> rsv_valid); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rsv_clr && !rsv_set) |=> !rsv_valid); // R8
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    !sc_req |=> !cond_vld); // R10
  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cond_vld |-> (!mem_we && cond_out == 4'd0 && mem_addr == '0 && mem_wdata == '0)); // R10
endmodule

bind rsv_unit rsv_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rsv_set(rsv_set), .rsv_clr(rsv_clr), .sc_req(sc_req),
  .ra_zero(ra_zero), .ra_val(ra_val), .rb_val(rb_val), .st_data(st_data),
  .so_in(so_in), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cond_vld(cond_vld), .cond_out(cond_out), .rsv_valid(rsv_valid)
);

// File: tb/rsv_unit_tb.sv
module rsv_unit_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rsv_set = 1'b0, rsv_clr = 1'b0, sc_req = 1'b0;
  logic          ra_zero = 1'b0, so_in = 1'b0;
  logic [AW-1:0] rsv_addr_in = '0, ra_val = '0, rb_val = '0;
  logic [DW-1:0] st_data = '0;
  logic          mem_we, cond_vld, rsv_valid;
  logic [AW-1:0] mem_addr, rsv_addr;
  logic [DW-1:0] mem_wdata;
  logic [3:0]    cond_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rsv_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rsv_set(rsv_set), .rsv_addr_in(rsv_addr_in),
    .rsv_clr(rsv_clr), .sc_req(sc_req), .ra_zero(ra_zero), .ra_val(ra_val),
    .rb_val(rb_val), .st_data(st_data), .so_in(so_in), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cond_vld(cond_vld),
    .cond_out(cond_out), .rsv_valid(rsv_valid), .rsv_addr(rsv_addr)
  );

  // vector: {set, clr, sc, ra_zero, so, exp_we, exp_cond[3:0], exp_valid}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    11'b00100_0_0000_0, // R2 R4 fail with flag clear
    11'b10000_0_0000_1, // R7 arm
    11'b00101_1_0011_0, // R1 R3 success, so copied
    11'b00101_0_0001_0, // R5 R4 second attempt fails
    11'b10000_0_0000_1, // R7 re-arm
    11'b01000_0_0000_0, // R8 clear
    11'b00100_0_0000_0, // R2 fail after clear
    11'b10000_0_0000_1, // R7
    11'b00110_1_0010_0, // R6 base zero success
    11'b10100_0_0000_1, // R9 set+sc, prior clear
    11'b10100_1_0010_1, // R9 set+sc, prior set
    11'b11000_0_0000_1, // R9 set beats clear
    11'b01101_1_0011_0, // R1 sc+clr on armed flag
    11'b00000_0_0000_0  // R10 idle, nothing valid
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_addr;
    logic [AW-1:0] last_set_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "rsv_valid", rsv_valid, 0);
    chk("R11", "cond_vld",  cond_vld, 0);
    chk("R11", "mem_we",    mem_we, 0);
    chk("R11", "rsv_addr",  rsv_addr, 0);
    rst = 1'b0;
    last_set_addr = '0;

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      rsv_set = v[10]; rsv_clr = v[9]; sc_req = v[8];
      ra_zero = v[7];  so_in = v[6];
      rsv_addr_in = 32'h1000 + AW'(i * 16);
      ra_val  = 32'h4000_0000 + AW'(i * 256);
      rb_val  = AW'(i * 4 + 8);
      st_data = 32'hA5A5_0000 + DW'(i);
      exp_addr = (v[7] ? '0 : ra_val) + rb_val;
      if (v[10]) last_set_addr = rsv_addr_in;
      @(negedge clk);
      chk("R1/R2", "mem_we", mem_we, v[5]);
      chk("R3/R4", "cond_out", cond_out, v[4:1]);
      chk("R10", "cond_vld", cond_vld, v[8]);
      chk("R5/R7/R8/R9", "rsv_valid", rsv_valid, v[0]);
      if (v[5]) begin
        chk("R6", "mem_addr", mem_addr, exp_addr);
        chk("R1", "mem_wdata", mem_wdata, st_data);
      end else begin
        chk("R10", "mem_addr idle", mem_addr, 0);
      end
      if (v[10]) chk("R7", "rsv_addr", rsv_addr, last_set_addr);
    end
    rsv_set = 0; rsv_clr = 0; sc_req = 0; ra_zero = 0; so_in = 0;

    // R10: result is a single-cycle pulse
    @(negedge clk);
    chk("R10", "cond_vld drop", cond_vld, 0);

    // R6: address wraps modulo 2^AW
    rsv_set = 1; rsv_addr_in = 32'hBEEF_0000;
    @(negedge clk);
    rsv_set = 0; sc_req = 1; ra_val = '1; rb_val = 32'd2; st_data = 32'h1234_5678;
    @(negedge clk);
    sc_req = 0;
    chk("R6", "wrap mem_addr", mem_addr, 32'd1);
    chk("R1", "wrap mem_we", mem_we, 1);

    // R11: reset in the middle of a reservation
    rsv_set = 1; rsv_addr_in = 32'h0000_0ABC;
    @(negedge clk);
    rsv_set = 0;
    chk("R7", "armed before reset", rsv_valid, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R11", "flag after reset", rsv_valid, 0);
    chk("R11", "addr after reset", rsv_addr, 0);
    sc_req = 1; so_in = 1;
    @(negedge clk);
    sc_req = 0; so_in = 0;
    chk("R2", "no write after reset", mem_we, 0);
    chk("R4", "fail cond after reset", cond_out, 4'b0001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule